// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Block

This block is one logic cell of a programmable fabric. Twenty-four signals from a shared routing bus feed a programmable AND plane that forms product terms. Two OR/XOR planes, each serving half of the eight outputs, turn those terms into output functions. Every output picks its own path: a wide masked OR over all twenty terms of its half, the same wide OR XORed with a dedicated term, a narrow fast OR over four dedicated terms, or a single dedicated term with selectable polarity. Each output is then either driven straight through or registered. The outputs go back onto the routing bus, where other cells use them.

The function is set by one wide configuration vector. The block captures that vector on the clock edges where the load strobe is high, and the vector is meant to stay constant while the block runs. Registered outputs use one fabric clock. Each register picks its capture strobe from three global clock enables or from a dedicated clock product term. A dedicated reset product term clears every register synchronously and overrides capture. An active-low global reset clears the registers asynchronously.

Top module: `pt_logic_block`

## Requirements
- R1: Product term p (0..41) is the AND of the literals its configuration enables. Bit p*48+2*i enables the true literal of bus input i, and bit p*48+2*i+1 enables the complement. A term with no enabled literal is 0, and a term that enables both literals of one input is 0.
- R2: Output o has a 26-bit field at bit 2016+26*o: path mode [1:0], polarity [2], register enable [3], strobe select [5:4], term mask [25:6]. In mode 0 the output is the OR of the masked terms of its half, XOR polarity.
- R3: In mode 1 the output is the OR of its four dedicated terms 4*j..4*j+3, where j is its index within the half. The polarity bit has no effect in this mode.
- R4: In mode 2 the output is the first dedicated term (4*j) XOR polarity.
- R5: In mode 3 the output is the masked OR of its half XOR its dedicated XOR term (16+j).
- R6: Outputs 0-3 use only terms 0..19 and outputs 4-7 use only terms 20..39. A mask bit k selects term k of the output's own half.
- R7: With register enable set, the output shows a register. The register loads the path value on a clock edge where its selected strobe is high and holds it otherwise.
- R8: Strobe select 0, 1 and 2 picks global clock enable 0, 1 and 2. Select 3 picks the clock product term (term 40).
- R9: While the reset product term (term 41) is high, every register clears at the clock edge, even when its strobe is high.
- R10: A low global reset clears every register at once, without a clock edge, and keeps it clear.
- R11: The configuration changes only on a clock edge with the load strobe high. Changes on the configuration input at other times have no effect on the outputs.
- R12: With register enable clear, the output follows the bus inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low global register reset, asynchronous |
| cfg_load | input | 1 | Configuration capture strobe |
| cfg_in | input | 2224 | Configuration vector |
| gclk_en | input | 3 | Global clock enables |
| grb_in | input | 24 | Routing bus inputs |
| blk_out | output | 8 | Output functions, returned to the routing bus |

## Verification
On every cycle the assertions check four things. The reset term beats any capture. A register without a strobe holds its value. A register with a global or product-term strobe takes the path value. The stored configuration moves only under the load strobe, and a term with contradictory literals stays low. The bench's scenarios cover what a property cannot: the value of each path mode for concrete input patterns, the masks staying within their own half, the polarity having no effect on the bypass path, the asynchronous clear taking effect with no edge, and the configuration input having no effect while the load strobe is low.

// File: rtl/pt_blk_pkg.sv
`timescale 1ns/1ps
package pt_blk_pkg;

   typedef enum logic [1:0] {
      PATH_WIDE_OR  = 2'd0,
      PATH_BYPASS   = 2'd1,
      PATH_SINGLE   = 2'd2,
      PATH_WIDE_XOR = 2'd3
   } path_mode_e;

   // per-output configuration field positions
   localparam int OCFG_MODE_LSB = 0;
   localparam int OCFG_POL      = 2;
   localparam int OCFG_REG      = 3;
   localparam int OCFG_SEL_LSB  = 4;
   localparam int OCFG_SEL_W    = 2;
   localparam int OCFG_MASK_LSB = 6;

endpackage

// File: rtl/pt_and_array.sv
`timescale 1ns/1ps
module pt_and_array #(
   parameter int N_IN = 24,
   parameter int N_PT = 42,
   localparam int PT_CFG_W = 2 * N_IN
) (
   input  logic [N_PT*PT_CFG_W-1:0] cfg_i,
   input  logic [N_IN-1:0]          lit_i,
   output logic [N_PT-1:0]          pt_o
);

   for (genvar p = 0; p < N_PT; p++) begin : g_pt
      logic [PT_CFG_W-1:0] c;
      logic [N_IN-1:0]     ok;
      assign c = cfg_i[p*PT_CFG_W +: PT_CFG_W];

      always_comb begin
         for (int i = 0; i < N_IN; i++) begin
            ok[i] = (!c[2*i] || lit_i[i]) && (!c[2*i+1] || !lit_i[i]);
         end
      end

      // a term with no literal enabled is forced low
      assign pt_o[p] = (|c) & (&ok);
   end

endmodule

// File: rtl/pt_or_xor.sv
`timescale 1ns/1ps
module pt_or_xor
   import pt_blk_pkg::*;
#(
   parameter int OPH         = 4,
   parameter int PT_PER_HALF = 20,
   parameter int BYP_PT      = 4
) (
   input  logic [PT_PER_HALF-1:0]     pt_i,
   input  logic [OPH*2-1:0]           mode_i,
   input  logic [OPH-1:0]             pol_i,
   input  logic [OPH*PT_PER_HALF-1:0] mask_i,
   output logic [OPH-1:0]             d_o
);

   localparam int XOR_BASE = OPH * BYP_PT;

   for (genvar j = 0; j < OPH; j++) begin : g_path
      logic       wide_or;
      logic       byp_or;
      logic       single_pt;
      logic       xor_pt;
      path_mode_e mode;

      assign wide_or   = |(pt_i & mask_i[j*PT_PER_HALF +: PT_PER_HALF]);
      assign byp_or    = |pt_i[j*BYP_PT +: BYP_PT];
      assign single_pt = pt_i[j*BYP_PT];
      assign xor_pt    = pt_i[XOR_BASE + j];
      assign mode      = path_mode_e'(mode_i[j*2 +: 2]);

      always_comb begin
         unique case (mode)
            PATH_WIDE_OR:  d_o[j] = wide_or ^ pol_i[j];
            PATH_BYPASS:   d_o[j] = byp_or;
            PATH_SINGLE:   d_o[j] = single_pt ^ pol_i[j];
            PATH_WIDE_XOR: d_o[j] = wide_or ^ xor_pt;
            default:       d_o[j] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/pt_out_cell.sv
`timescale 1ns/1ps
module pt_out_cell #(
   parameter int N_GCLK = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_i,
   input  logic              reg_en_i,
   input  logic [1:0]        sel_i,
   input  logic [N_GCLK-1:0] gclk_en_i,
   input  logic              pt_clk_i,
   input  logic              pt_rst_i,
   output logic              y_o
);

   logic stb;
   logic q;

   // select codes beyond the global enables pick the clock term
   always_comb begin
      stb = pt_clk_i;
      for (int k = 0; k < N_GCLK; k++) begin
         if (int'(sel_i) == k) stb = gclk_en_i[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (pt_rst_i) q <= 1'b0;
      else if (stb)      q <= d_i;
   end

   assign y_o = reg_en_i ? q : d_i;

   assert_ptrst_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pt_rst_i |=> (q == 1'b0));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pt_rst_i && !stb) |=> $stable(q));

   assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pt_rst_i && stb) |=> (q == $past(d_i)));

   assert_ptclk_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pt_rst_i && (int'(sel_i) >= N_GCLK) && pt_clk_i) |=> (q == $past(d_i)));

endmodule

// File: rtl/pt_logic_block.sv
`timescale 1ns/1ps
module pt_logic_block
   import pt_blk_pkg::*;
#(
   parameter int N_IN        = 24,
   parameter int N_OUT       = 8,
   parameter int PT_PER_HALF = 20,
   parameter int BYP_PT      = 4,
   parameter int N_GCLK      = 3,
   localparam int OPH        = N_OUT / 2,
   localparam int N_PT       = 2 * PT_PER_HALF + 2,
   localparam int PT_CFG_W   = 2 * N_IN,
   localparam int OCFG_W     = OCFG_MASK_LSB + PT_PER_HALF,
   localparam int OCFG_BASE  = N_PT * PT_CFG_W,
   localparam int CFG_W      = OCFG_BASE + N_OUT * OCFG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [CFG_W-1:0]  cfg_in,
   input  logic [N_GCLK-1:0] gclk_en,
   input  logic [N_IN-1:0]   grb_in,
   output logic [N_OUT-1:0]  blk_out
);

   localparam int PT_CLK = N_PT - 2;
   localparam int PT_RST = N_PT - 1;

   // elaboration-time parameter checks
   if (N_OUT < 2 || N_OUT != 2 * OPH) begin : g_bad_nout
      $error("pt_logic_block: N_OUT must be even and at least 2");
   end
   if (BYP_PT < 1 || PT_PER_HALF < OPH * (BYP_PT + 1)) begin : g_bad_pt
      $error("pt_logic_block: PT_PER_HALF too small for bypass and XOR terms");
   end
   if (N_GCLK < 1 || N_GCLK > 3) begin : g_bad_gclk
      $error("pt_logic_block: N_GCLK must be 1 to 3");
   end
   if (N_IN < 1) begin : g_bad_nin
      $error("pt_logic_block: N_IN must be positive");
   end

   logic [CFG_W-1:0]             cfg_q;
   logic [N_PT-1:0]              pt;
   logic [N_OUT*2-1:0]           mode_v;
   logic [N_OUT-1:0]             pol_v;
   logic [N_OUT-1:0]             reg_v;
   logic [N_OUT*2-1:0]           sel_v;
   logic [N_OUT*PT_PER_HALF-1:0] mask_v;
   logic [N_OUT-1:0]             d_v;

   // configuration store: loaded only under the strobe
   always_ff @(posedge clk) begin
      if (cfg_load) cfg_q <= cfg_in;
   end

   pt_and_array #(
      .N_IN (N_IN),
      .N_PT (N_PT)
   ) u_and (
      .cfg_i (cfg_q[OCFG_BASE-1:0]),
      .lit_i (grb_in),
      .pt_o  (pt)
   );

   for (genvar o = 0; o < N_OUT; o++) begin : g_ocfg
      logic [OCFG_W-1:0] f;
      assign f = cfg_q[OCFG_BASE + o*OCFG_W +: OCFG_W];
      assign mode_v[o*2 +: 2]                   = f[OCFG_MODE_LSB +: 2];
      assign pol_v[o]                           = f[OCFG_POL];
      assign reg_v[o]                           = f[OCFG_REG];
      assign sel_v[o*2 +: 2]                    = f[OCFG_SEL_LSB +: OCFG_SEL_W];
      assign mask_v[o*PT_PER_HALF +: PT_PER_HALF] = f[OCFG_MASK_LSB +: PT_PER_HALF];
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      pt_or_xor #(
         .OPH         (OPH),
         .PT_PER_HALF (PT_PER_HALF),
         .BYP_PT      (BYP_PT)
      ) u_orx (
         .pt_i   (pt[h*PT_PER_HALF +: PT_PER_HALF]),
         .mode_i (mode_v[h*OPH*2 +: OPH*2]),
         .pol_i  (pol_v[h*OPH +: OPH]),
         .mask_i (mask_v[h*OPH*PT_PER_HALF +: OPH*PT_PER_HALF]),
         .d_o    (d_v[h*OPH +: OPH])
      );
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_cell
      pt_out_cell #(
         .N_GCLK (N_GCLK)
      ) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .d_i       (d_v[o]),
         .reg_en_i  (reg_v[o]),
         .sel_i     (sel_v[o*2 +: 2]),
         .gclk_en_i (gclk_en),
         .pt_clk_i  (pt[PT_CLK]),
         .pt_rst_i  (pt[PT_RST]),
         .y_o       (blk_out[o])
      );
   end

   assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(cfg_q));

   for (genvar p = 0; p < N_PT; p++) begin : g_chk_pt
      logic [N_IN-1:0] t_en;
      logic [N_IN-1:0] c_en;
      for (genvar i = 0; i < N_IN; i++) begin : g_lit
         assign t_en[i] = cfg_q[p*PT_CFG_W + 2*i];
         assign c_en[i] = cfg_q[p*PT_CFG_W + 2*i + 1];
      end
      assert_contradiction_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (|(t_en & c_en)) |-> !pt[p]);
   end

endmodule

// File: tb/tb_pt_logic_block.sv
`timescale 1ns/100ps
module tb_pt_logic_block;

   localparam int CFG_W = 42 * 48 + 8 * 26;
   localparam int OBASE = 42 * 48;

   // {bus inputs[23:0], expected outputs[7:0]} for the combinational setup
   localparam logic [31:0] VEC_TAB [17] = '{
      32'h000000C5, 32'h000004C4, 32'h000007C7, 32'h000207C5,
      32'h000044C2, 32'h000014CC, 32'h000034C4, 32'h000084CC,
      32'h001C04F4, 32'h00200484, 32'h00800484, 32'h00400444,
      32'h024004C4, 32'h02000444, 32'h00000CC5, 32'h000005C4,
      32'hFFFFFFB9
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cfg_load;
   logic [CFG_W-1:0] cfg_in;
   logic [2:0]       gclk_en;
   logic [23:0]      grb_in;
   logic [7:0]       blk_out;
   logic [CFG_W-1:0] cfg_b;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   pt_logic_block dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .cfg_in   (cfg_in),
      .gclk_en  (gclk_en),
      .grb_in   (grb_in),
      .blk_out  (blk_out)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic lit(input int p, input int i, input bit comp);
      cfg_b[p*48 + 2*i + (comp ? 1 : 0)] = 1'b1;
   endtask

   task automatic set_out(input int o, input logic [1:0] mode, input bit pol,
                          input bit rg, input logic [1:0] sel, input logic [19:0] mask);
      int b;
      b = OBASE + o * 26;
      cfg_b[b]   = mode[0];
      cfg_b[b+1] = mode[1];
      cfg_b[b+2] = pol;
      cfg_b[b+3] = rg;
      cfg_b[b+4] = sel[0];
      cfg_b[b+5] = sel[1];
      for (int k = 0; k < 20; k++) cfg_b[b+6+k] = mask[k];
   endtask

   task automatic build(input bit rg);
      cfg_b = '0;
      lit(0, 0, 0); lit(0, 1, 0);      // in0 & in1
      lit(1, 2, 1);                    // ~in2
      lit(2, 3, 0);                    // in3
      lit(4, 4, 0); lit(4, 5, 1);      // in4 & ~in5
      lit(5, 0, 0); lit(5, 0, 1);      // contradiction, R1
      lit(8, 6, 0);
      lit(12, 7, 0);
      lit(16, 8, 0);
      lit(17, 9, 0);
      lit(20, 10, 0);
      lit(24, 11, 0); lit(24, 12, 0);
      lit(28, 13, 0);
      lit(32, 14, 1);
      lit(36, 15, 0);
      lit(39, 17, 0);
      lit(40, 20, 0);                  // clock term
      lit(41, 21, 0);                  // reset term
      set_out(0, 2'd1, 1'b1, rg, 2'd0, 20'h00000);
      set_out(1, 2'd3, 1'b0, rg, 2'd1, 20'h00101);
      set_out(2, 2'd2, 1'b1, rg, 2'd2, 20'h00000);
      set_out(3, 2'd0, 1'b0, rg, 2'd3, 20'h01030);
      set_out(4, 2'd2, 1'b0, 1'b0, 2'd0, 20'h00000);
      set_out(5, 2'd1, 1'b0, 1'b0, 2'd0, 20'h00000);
      set_out(6, 2'd0, 1'b1, 1'b0, 2'd0, 20'h10100);
      set_out(7, 2'd3, 1'b0, 1'b0, 2'd0, 20'h01000);
   endtask

   task automatic load_cfg();
      @(negedge clk);
      cfg_in = cfg_b;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic step(input logic [23:0] in, input logic [2:0] gen);
      @(negedge clk);
      grb_in = in;
      gclk_en = gen;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      cfg_load = 1'b0;
      cfg_in = '0;
      gclk_en = 3'b000;
      grb_in = 24'h0;

      // reset state with registered setup, R10
      build(1'b1);
      load_cfg();
      #1;
      check("R10 reset state", blk_out, 8'hC0);

      // combinational setup and vector table
      build(1'b0);
      load_cfg();
      @(negedge clk);
      rst_n = 1'b1;
      for (int r = 0; r < 17; r++) begin
         grb_in = VEC_TAB[r][31:8];
         #1;
         check($sformatf("R1/R2/R3/R4/R5/R6/R12 row %0d", r), blk_out, VEC_TAB[r][7:0]);
      end

      // configuration input ignored without the load strobe, R11
      cfg_in = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      grb_in = 24'h000000;
      #1;
      check("R11 cfg ignored", blk_out, 8'hC5);
      grb_in = 24'hFFFFFF;
      #1;
      check("R11 cfg ignored all ones", blk_out, 8'hB9);

      // registered setup
      grb_in = 24'h0;
      build(1'b1);
      load_cfg();
      rst_n = 1'b0;
      #1;
      check("R10 async clear", blk_out, 8'hC0);
      @(negedge clk);
      rst_n = 1'b1;

      step(24'h000000, 3'b000);
      check("R7 hold without strobe", blk_out, 8'hC0);
      step(24'h000000, 3'b001);
      check("R8 gclk0 capture", blk_out, 8'hC1);
      step(24'h000000, 3'b100);
      check("R8 gclk2 capture", blk_out, 8'hC5);
      step(24'h000044, 3'b010);
      check("R8 gclk1 capture", blk_out, 8'hC7);
      step(24'h100084, 3'b000);
      check("R8 clock term capture", blk_out, 8'hCF);
      step(24'h000004, 3'b000);
      check("R7 hold with clock term low", blk_out, 8'hCF);
      step(24'h300003, 3'b111);
      check("R9 reset term wins", blk_out, 8'hC0);
      step(24'h100003, 3'b111);
      check("R9 capture after reset term", blk_out, 8'hC7);

      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10 async clear no edge", blk_out, 8'hC0);
      @(posedge clk);
      #1;
      check("R10 stays clear", blk_out, 8'hC0);
      @(negedge clk);
      rst_n = 1'b1;

      finish_run();
   end

endmodule